// File: doc/BRIEF.md
# Paged Parallel Memory Host Controller

This block sits between an on-chip requester and an external asynchronous byte-wide nonvolatile RAM. The requester offers one byte read or write at a time on a valid/ready handshake. The controller turns each request into chip-enable, write-enable, output-enable, address and data-bus activity. Every analogue timing limit of the memory is derived from a clock-period parameter by rounding up to whole cycles, with a floor of one cycle.

The controller remembers which row (the address bits above the column field) is open while chip enable is low. A request to that row is served as a page access that changes only the column bits. A request to another row, or no request at all, makes the controller close the row, hold chip enable high for the precharge time, and start a fresh random access. After reset the controller waits out the memory's power-up time before the first access. Read data comes back on a one-cycle valid strobe.

Top module: `pmem_host_ctrl`

## Requirements
- R1: While reset is asserted and during the power-up wait, mem_ce_n, mem_we_n and mem_oe_n are high, mem_dq_oe is low and req_ready is low.
- R2: After reset is released, req_ready stays low and chip enable stays high for ceil(T_PU_NS / CLK_PERIOD_NS) cycles (31250 at defaults).
- R3: A request accepted with chip enable high puts its address on mem_addr at least one cycle before chip enable falls. A read then returns the stored byte on rsp_rdata together with a single-cycle rsp_valid pulse.
- R4: The row is req_addr[ADDR_W-1:COL_W] and the column is req_addr[COL_W-1:0]. A request whose row equals the open row, arriving while chip enable is low, is served without chip enable rising: a back-to-back burst inside one row causes exactly one chip-enable falling edge.
- R5: A request to a different row closes the open row. Chip enable stays high for at least 9 cycles (70 ns at 8 ns) before it falls again, so a back-to-back burst alternating between two rows gives one falling edge per request.
- R6: Every chip-enable low period lasts at least 9 cycles (70 ns).
- R7: Write enable goes low only while chip enable is low, stays low for at least 4 cycles (the largest of pulse width, data setup, column hold and the write-low-to-deselect limit), and the write data is driven for the whole low period and at the rising edge. The written byte reads back unchanged.
- R8: mem_dq_oe is never high while mem_oe_n is low.
- R9: When no request is pending after an access, chip enable returns high and stays high.
- R10: Read data is sampled only after 70 ns from the chip-enable fall, 60 ns from a column change and 15 ns from the output-enable fall have all elapsed.
- R11: Every accepted read produces exactly one rsp_valid pulse, in request order, and writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken at this clock edge if req_valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle strobe for returned read data |
| rsp_rdata | output | DATA_W | Returned read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data driver toward the memory |
| mem_dq_in | input | DATA_W | Data read from the memory bus |

## Verification
In the open-row state, the decision to close the row for lack of work can land on the same cycle as a new request that would have hit that row. The bench provokes this by following a read with a second read to the same row after gaps of zero to three cycles, so the new request arrives just before, at, or after the close decision. The outcome is judged from the returned data, which the memory model only produces when every access time for that path has elapsed. Continuous pin monitors judge the precharge and chip-enable low times, so both a page hit and a close-then-reopen are legal, but a page access with a stale column timing or a reopen with a short precharge is not.

// File: rtl/pmem_pkg.sv
// Package: shared state type and timing helpers for the paged memory
// host controller. Assumes all timing inputs are non-negative nanoseconds.
package pmem_pkg;

    typedef enum logic [3:0] {
        S_PWRUP,   // waiting out supply-to-first-access time
        S_IDLE,    // deselected, precharge satisfied
        S_SETUP,   // address presented, chip enable still high
        S_ACT,     // chip enable low, row access in progress
        S_RD,      // output enable low, waiting for valid data
        S_RDREL,   // output enable high, bus turning around
        S_OPEN,    // row open, waiting for a same-row request
        S_PCOL,    // new column presented inside open row
        S_WRLO,    // write enable low, data driven
        S_WRHOLD,  // write enable high, data still driven
        S_PRECH    // chip enable high, precharge running
    } pmem_state_e;

    // Round a nanosecond limit up to clock cycles, never below one cycle.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Difference a-b, never below one.
    function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/pmem_delay_cnt.sv
// Module: loadable down-counter that times every controller phase.
// Loading N makes the following phase last N cycles; last is high in the
// final cycle. Assumes load values of at least one.
module pmem_delay_cnt #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Count down toward one; reset preloads the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt > 1)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt <= 1);

    // A zero load would make a phase vanish and break every timing rule.
    a_r6_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/pmem_open_row.sv
// Module: remembers the row left open by the controller and reports
// whether a requested row matches it. Assumes open and close never coincide.
module pmem_open_row #(
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             hit_o
);
    logic [ROW_W-1:0] row_q;
    logic             vld_q;

    // Capture the row on open, forget it on close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            vld_q <= 1'b0;
        end else if (open_i) begin
            row_q <= row_i;
            vld_q <= 1'b1;
        end else if (close_i) begin
            vld_q <= 1'b0;
        end
    end

    assign hit_o = vld_q && (row_q == row_i);

    a_r4_open_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_i && close_i));

endmodule

// File: rtl/pmem_host_ctrl.sv
// Module: host-side controller for an asynchronous byte-wide memory with
// page access inside a row. Converts valid/ready byte requests into timed
// strobes; every limit is a cycle count derived from CLK_PERIOD_NS.
// Assumes mem_dq_in is stable when sampled (the pad is outside this block)
// and that the requester holds request fields while req_valid is high.
module pmem_host_ctrl
    import pmem_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned COL_W     = 3,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned T_RC_NS   = 140,
    parameter int unsigned T_CE_NS   = 70,
    parameter int unsigned T_CA_NS   = 70,
    parameter int unsigned T_PC_NS   = 70,
    parameter int unsigned T_AAP_NS  = 60,
    parameter int unsigned T_AS_NS   = 0,
    parameter int unsigned T_AH_NS   = 70,
    parameter int unsigned T_WP_NS   = 18,
    parameter int unsigned T_DS_NS   = 15,
    parameter int unsigned T_DH_NS   = 0,
    parameter int unsigned T_ASP_NS  = 5,
    parameter int unsigned T_AHP_NS  = 15,
    parameter int unsigned T_WLC_NS  = 25,
    parameter int unsigned T_OE_NS   = 15,
    parameter int unsigned T_HZ_NS   = 10,
    parameter int unsigned T_PU_NS   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned ROW_W  = ADDR_W - COL_W;
    localparam int unsigned P      = CLK_PERIOD_NS;
    localparam int unsigned C_RC   = ns2cyc(T_RC_NS, P);
    localparam int unsigned C_CA   = ns2cyc(T_CA_NS, P);
    localparam int unsigned C_PC   = ns2cyc(T_PC_NS, P);
    localparam int unsigned C_AS   = ns2cyc(T_AS_NS, P);
    localparam int unsigned C_ASP  = ns2cyc(T_ASP_NS, P);
    localparam int unsigned C_DH   = ns2cyc(T_DH_NS, P);
    localparam int unsigned C_OE   = ns2cyc(T_OE_NS, P);
    localparam int unsigned C_HZ   = ns2cyc(T_HZ_NS, P);
    localparam int unsigned C_PU   = ns2cyc(T_PU_NS, P);
    localparam int unsigned C_WP   = ns2cyc(T_WP_NS, P);
    localparam int unsigned C_ACT  = max2(max2(ns2cyc(T_CE_NS, P), ns2cyc(T_AH_NS, P)), C_CA);
    localparam int unsigned C_WL   = max2(max2(C_WP, ns2cyc(T_DS_NS, P)),
                                          max2(ns2cyc(T_AHP_NS, P), ns2cyc(T_WLC_NS, P)));
    localparam int unsigned C_PGRD = max2(ns2cyc(T_AAP_NS, P), C_OE);
    localparam int unsigned C_PRE  = max2(C_PC, sub_floor1(C_RC, C_ACT));
    localparam int unsigned CNT_W  = $clog2(max2(C_PU, C_RC) + 2);

    pmem_state_e       state, nxt;
    logic              t_load, t_last, accept, row_hit;
    logic [CNT_W-1:0]  t_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;

    pmem_delay_cnt #(.CNT_W(CNT_W), .RST_VAL(C_PU)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    pmem_open_row #(.ROW_W(ROW_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (accept && (state == S_IDLE)),
        .close_i ((nxt == S_PRECH) && (state != S_PRECH)),
        .row_i   (req_addr[ADDR_W-1:COL_W]),
        .hit_o   (row_hit)
    );

    // Next state, phase length and request acceptance.
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = CNT_W'(1);
        accept = 1'b0;
        unique case (state)
            S_PWRUP: if (t_last) nxt = S_IDLE;
            S_IDLE: if (req_valid) begin
                accept = 1'b1; nxt = S_SETUP; t_load = 1'b1; t_val = CNT_W'(C_AS);
            end
            S_SETUP: if (t_last) begin
                nxt = S_ACT; t_load = 1'b1; t_val = CNT_W'(C_ACT);
            end
            S_ACT: if (t_last) begin
                t_load = 1'b1;
                if (wr_q) begin nxt = S_WRLO; t_val = CNT_W'(C_WL); end
                else      begin nxt = S_RD;   t_val = CNT_W'(C_OE); end
            end
            S_RD: if (t_last) begin
                nxt = S_RDREL; t_load = 1'b1; t_val = CNT_W'(C_HZ);
            end
            S_RDREL: if (t_last) nxt = S_OPEN;
            S_OPEN: begin
                t_load = 1'b1;
                if (req_valid && row_hit) begin
                    accept = 1'b1; nxt = S_PCOL; t_val = CNT_W'(C_ASP);
                end else begin
                    nxt = S_PRECH; t_val = CNT_W'(C_PRE);
                end
            end
            S_PCOL: if (t_last) begin
                t_load = 1'b1;
                if (wr_q) begin nxt = S_WRLO; t_val = CNT_W'(C_WL);   end
                else      begin nxt = S_RD;   t_val = CNT_W'(C_PGRD); end
            end
            S_WRLO: if (t_last) begin
                nxt = S_WRHOLD; t_load = 1'b1; t_val = CNT_W'(C_DH);
            end
            S_WRHOLD: if (t_last) nxt = S_OPEN;
            S_PRECH: if (t_last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_PWRUP;
        else        state <= nxt;
    end

    // Latch the accepted request; address and data feed the pins directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
        end
    end

    // Sample read data at the last cycle of the output-enable phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == S_RD) && t_last;
            if ((state == S_RD) && t_last) rsp_rdata <= mem_dq_in;
        end
    end

    assign req_ready  = (state == S_IDLE) || ((state == S_OPEN) && row_hit);
    assign mem_ce_n   = !(state inside {S_ACT, S_RD, S_RDREL, S_OPEN, S_PCOL, S_WRLO, S_WRHOLD});
    assign mem_we_n   = (state != S_WRLO);
    assign mem_oe_n   = (state != S_RD);
    assign mem_dq_oe  = (state == S_WRLO) || (state == S_WRHOLD);
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // Assertion support: run lengths of pin levels since reset.
    logic [CNT_W-1:0] up_cnt, ce_hi_cnt, ce_lo_cnt, we_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_cnt <= '0; ce_hi_cnt <= '0; ce_lo_cnt <= '0; we_lo_cnt <= '0;
        end else begin
            if (up_cnt < CNT_W'(C_PU)) up_cnt <= up_cnt + 1'b1;
            ce_hi_cnt <= !mem_ce_n ? '0 : ((ce_hi_cnt < CNT_W'(C_PC)) ? ce_hi_cnt + 1'b1 : ce_hi_cnt);
            ce_lo_cnt <=  mem_ce_n ? '0 : ((ce_lo_cnt < CNT_W'(C_CA)) ? ce_lo_cnt + 1'b1 : ce_lo_cnt);
            we_lo_cnt <=  mem_we_n ? '0 : ((we_lo_cnt < CNT_W'(C_WL)) ? we_lo_cnt + 1'b1 : we_lo_cnt);
        end
    end

    a_r2_powerup_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (up_cnt >= CNT_W'(C_PU)));
    a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (ce_hi_cnt >= CNT_W'(C_PC)));
    a_r6_ce_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (ce_lo_cnt >= CNT_W'(C_CA)));
    a_r7_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt >= CNT_W'(C_WL)));
    a_r7_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);
    a_r7_data_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);
    a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/pmem_host_ctrl_tb.sv
// Bench: scoreboard-driven test of pmem_host_ctrl with a cycle-level model
// of an asynchronous memory that returns 8'hEE whenever an access time
// has not yet elapsed.
module pmem_host_ctrl_tb;
    localparam int TB_P    = 8;
    localparam int TB_PU   = 250000 / TB_P;   // 31250 cycles
    localparam int TB_PC   = 9;               // 70 ns rounded up
    localparam int TB_CA   = 9;
    localparam int TB_WL   = 4;               // 25 ns write-low-to-deselect rounds to 4
    localparam logic [7:0] BAD = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
    logic [14:0] mem_addr;

    always #4 clk = ~clk;

    pmem_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // ---- memory model ----
    logic [7:0]  mem_m [int];
    int          ce_lo_t = 0, oe_lo_t = 0, col_t = 0;
    logic [14:0] addr_prev = '0;

    always @(posedge mem_we_n)
        if (mem_ce_n === 1'b0) mem_m[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : BAD;

    always @(posedge clk) begin
        ce_lo_t   <= mem_ce_n ? 0 : ce_lo_t + 1;
        oe_lo_t   <= mem_oe_n ? 0 : oe_lo_t + 1;
        col_t     <= (mem_addr != addr_prev) ? 0 : col_t + 1;
        addr_prev <= mem_addr;
    end

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n &&
                        (ce_lo_t + 1) * TB_P >= 70 && (oe_lo_t + 1) * TB_P >= 15 &&
                        (col_t + 2) * TB_P >= 60)
                       ? (mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00) : BAD;

    // ---- pin monitors ----
    int  ce_falls = 0, hi_run = 0, lo_run = 0, we_lo_run = 0, up_cyc = 0;
    int  v_pc = 0, v_ca = 0, v_we = 0, v_drv = 0, v_wl = 0, v_pu = 0;
    bit  prev_ce = 1, prev_we = 1;
    always @(negedge clk) if (rst_n) begin
        up_cyc++;
        if (prev_ce && !mem_ce_n) begin
            ce_falls++;
            if (hi_run < TB_PC) v_pc++;
            if (up_cyc <= TB_PU) v_pu++;
        end
        if (!prev_ce && mem_ce_n && lo_run < TB_CA) v_ca++;
        if (!prev_we && mem_we_n && (we_lo_run < TB_WL || !mem_dq_oe)) v_wl++;
        if (!mem_we_n && mem_ce_n) v_we++;
        if (!mem_we_n && !mem_dq_oe) v_wl++;
        if (mem_dq_oe && !mem_oe_n) v_drv++;
        hi_run    = mem_ce_n ? hi_run + 1 : 0;
        lo_run    = mem_ce_n ? 0 : lo_run + 1;
        we_lo_run = mem_we_n ? 0 : we_lo_run + 1;
        prev_ce   = mem_ce_n;
        prev_we   = mem_we_n;
    end

    // ---- scoreboard ----
    logic [7:0]  shadow [int];
    logic [7:0]  exp_q [$];
    int          n_rd_sent = 0, n_rsp = 0;

    always @(negedge clk) if (rst_n && rsp_valid) begin
        n_rsp++;
        if (exp_q.size() == 0)
            chk(0, "R11 response without pending read", n_rsp, n_rd_sent);
        else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R3/R10 read data", rsp_rdata, e);
        end
    end

    // Driver: called at a negedge; leaves req_valid low at the next negedge.
    task automatic send(input bit wr, input logic [14:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (wr) shadow[int'(a)] = d;
        else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
            n_rd_sent++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic quiet();
        repeat (60) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int base, waited;
        repeat (5) @(negedge clk);
        // R1 reset levels
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk(!mem_dq_oe && !req_ready && !rsp_valid, "R1 bus and handshake idle in reset",
            {mem_dq_oe, req_ready, rsp_valid}, 0);
        rst_n = 1'b1;
        // R2 power-up wait
        waited = 0;
        while (!req_ready && waited < TB_PU + 10) begin @(negedge clk); waited++; end
        chk(waited >= TB_PU && waited <= TB_PU + 2, "R2 power-up wait length", waited, TB_PU);
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes idle after power-up",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 14);

        // R3 random write then random read on another row
        send(1, 15'h0123, 8'h5A); quiet();
        send(1, 15'h7F08, 8'hC3); quiet();
        base = ce_falls;
        send(0, 15'h0123, 8'h00); quiet();
        chk(ce_falls - base == 1, "R3 single random access", ce_falls - base, 1);
        send(0, 15'h7F08, 8'h00); quiet();

        // R4 page write burst in one row, columns out of order
        base = ce_falls;
        for (int i = 0; i < 8; i++)
            send(1, {12'h040, 3'((i * 5) % 8)}, 8'(8'h10 + i));
        quiet();
        chk(ce_falls - base == 1, "R4 page write burst one CE fall", ce_falls - base, 1);
        base = ce_falls;
        for (int i = 0; i < 8; i++)
            send(0, {12'h040, 3'((i * 3) % 8)}, 8'h00);
        quiet();
        chk(ce_falls - base == 1, "R4 page read burst one CE fall", ce_falls - base, 1);

        // R4/R7 mixed reads and writes inside one row
        base = ce_falls;
        send(1, 15'h2A01, 8'h61); send(0, 15'h2A01, 8'h00);
        send(1, 15'h2A06, 8'h62); send(0, 15'h2A06, 8'h00); send(0, 15'h2A01, 8'h00);
        quiet();
        chk(ce_falls - base == 1, "R4 mixed page burst one CE fall", ce_falls - base, 1);

        // R5 alternating rows back to back
        base = ce_falls;
        send(0, 15'h0123, 8'h00); send(0, 15'h7F08, 8'h00);
        send(0, 15'h0125, 8'h00); send(1, 15'h7F09, 8'h77);
        quiet();
        chk(ce_falls - base == 4, "R5 row miss reopens", ce_falls - base, 4);
        send(0, 15'h7F09, 8'h00); quiet();

        // R9 idle close
        chk(mem_ce_n == 1'b1, "R9 CE high when no request", mem_ce_n, 1);
        repeat (20) @(negedge clk);
        chk(mem_ce_n == 1'b1 && hi_run >= 20, "R9 CE stays high", hi_run, 20);

        // Close decision racing a same-row request
        for (int g = 0; g < 4; g++) begin
            send(0, {12'h040, 3'(g)}, 8'h00);
            repeat (g) @(negedge clk);
            send(0, {12'h040, 3'(7 - g)}, 8'h00);
            quiet();
        end

        quiet();
        chk(exp_q.size() == 0 && n_rsp == n_rd_sent, "R11 one response per read", n_rsp, n_rd_sent);
        chk(v_pu == 0,  "R2 no access during power-up", v_pu, 0);
        chk(v_pc == 0,  "R5 precharge length", v_pc, 0);
        chk(v_ca == 0,  "R6 CE low length", v_ca, 0);
        chk(v_we == 0,  "R7 WE only while CE low", v_we, 0);
        chk(v_wl == 0,  "R7 WE width and data drive", v_wl, 0);
        chk(v_drv == 0, "R8 no drive with OE low", v_drv, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule